// File: doc/BRIEF.md
# Bidirectional Latched Inverting Transceiver

This block joins two 16-bit buses, called side A and side B, through a pair of storage stages per direction. The bus is cut into independent groups, two groups of eight bits by default. Each group can move data from A toward B and from B toward A. Each direction of each group has three active-low controls: a chip enable, a latch enable and an output enable. A word entered from one side is held in that direction's storage and driven onto the other side in inverted form. The groups can be run as separate narrow transceivers or switched together as one wide transceiver.

Every port is modelled as an input value, an output value and an output-enable per group. A wrapper higher up in the chip turns these into a real tri-state pad. The block runs on a clock. Controls and data are treated as changing only between clock edges. While a direction's storage is open, its output follows the input within the same cycle. At each clock edge the storage captures the value that was on the input during that cycle. When the storage closes, its output therefore shows the word from the last open cycle.

Top module: `xcv_bidir_latch`

## Requirements
- R1: Each group of GRP_W bits (group g covers bits g*GRP_W up to g*GRP_W+GRP_W-1) obeys only its own control bits at index g. Changing the controls of one group leaves the drive and data of every other group unchanged.
- R2: While a direction's chip enable (ce_*_n) is 1, that direction's output-enable for the group is 0, whatever its latch and output enables are.
- R3: While the chip enable is 0 and the output enable (oe_*_n) is 1, the output-enable for the group is 0.
- R4: While chip enable, latch enable and output enable are all 0, the output-enable is 1 and each output bit is the complement of the matching input bit in the same cycle.
- R5: At a clock edge where the chip enable and latch enable are both 0, the storage takes the input value. After the latch enable goes to 1, the output is the complement of the value from the last open cycle.
- R6: While the latch enable or the chip enable is 1, the storage does not change, so a driven output stays stable whatever the input does.
- R7: The B-to-A direction follows R2 to R6 with its own controls (ce_ba_n, le_ba_n, oe_ba_n), input b_in and outputs a_out/a_oe, independently of the A-to-B controls.
- R8: Reset (rst_n = 0) clears all storage to zero. A closed, driving direction then presents all ones.
- R9: Both directions of a group can hold words at the same time. Only the direction whose chip enable and output enable are 0 drives its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears storage |
| a_in | input | 16 | Value seen on side A |
| b_in | input | 16 | Value seen on side B |
| ce_ab_n | input | 2 | A-to-B chip enable per group, active low |
| le_ab_n | input | 2 | A-to-B latch enable per group, active low |
| oe_ab_n | input | 2 | A-to-B output enable per group, active low |
| ce_ba_n | input | 2 | B-to-A chip enable per group, active low |
| le_ba_n | input | 2 | B-to-A latch enable per group, active low |
| oe_ba_n | input | 2 | B-to-A output enable per group, active low |
| b_out | output | 16 | Data to drive onto side B |
| b_oe | output | 2 | Side B drive enable per group |
| a_out | output | 16 | Data to drive onto side A |
| a_oe | output | 2 | Side A drive enable per group |

## Verification
The assertions take for granted that the data and control inputs change only between clock edges and stay fixed around the rising edge. Only then is the clocked storage the same as a level latch, and only then do the hold and capture properties look at the value the storage really saw. The bench applies every new input pattern just after a falling edge and keeps it until the next falling edge. The random control bits and data therefore never move near a capturing edge. Whether the storage is open is judged from the controls already applied at the edge, and the properties compare against those values.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
   // control set of one direction of one group, all active low
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } xcv_ctrl_t;

   function automatic logic xcv_open(input xcv_ctrl_t c);
      return !c.ce_n && !c.le_n;
   endfunction

   function automatic logic xcv_drive(input xcv_ctrl_t c);
      return !c.ce_n && !c.oe_n;
   endfunction
endpackage

// File: rtl/xcv_lane.sv
module xcv_lane
   import xcv_pkg::*;
#(
   parameter int GRP_W      = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xcv_ctrl_t        ctrl,
   input  logic [GRP_W-1:0] din,
   output logic [GRP_W-1:0] dout,
   output logic             drive
);
   logic [GRP_W-1:0] held_q;
   logic [GRP_W-1:0] view;
   logic             open_w;

   assign open_w = xcv_open(ctrl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= '0;
      else if (open_w) held_q <= din;
   end

   assign view  = open_w ? din : held_q;
   assign drive = xcv_drive(ctrl);

   generate
      if (INVERT_OUT) begin : g_inv
         assign dout = ~view;
      end else begin : g_true
         assign dout = view;
      end
   endgenerate
endmodule

// File: rtl/xcv_group.sv
module xcv_group
   import xcv_pkg::*;
#(
   parameter int GRP_W      = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xcv_ctrl_t        ctrl_ab,
   input  xcv_ctrl_t        ctrl_ba,
   input  logic [GRP_W-1:0] a_in,
   input  logic [GRP_W-1:0] b_in,
   output logic [GRP_W-1:0] b_out,
   output logic             b_oe,
   output logic [GRP_W-1:0] a_out,
   output logic             a_oe
);
   xcv_lane #(.GRP_W(GRP_W), .INVERT_OUT(INVERT_OUT)) i_ab (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (ctrl_ab),
      .din   (a_in),
      .dout  (b_out),
      .drive (b_oe)
   );

   xcv_lane #(.GRP_W(GRP_W), .INVERT_OUT(INVERT_OUT)) i_ba (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (ctrl_ba),
      .din   (b_in),
      .dout  (a_out),
      .drive (a_oe)
   );
endmodule

// File: rtl/xcv_bidir_latch.sv
module xcv_bidir_latch
   import xcv_pkg::*;
#(
   parameter int GRP_W      = 8,
   parameter int NUM_GRP    = 2,
   parameter bit INVERT_OUT = 1'b1,
   localparam int BUS_W     = GRP_W * NUM_GRP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BUS_W-1:0]   a_in,
   input  logic [BUS_W-1:0]   b_in,
   input  logic [NUM_GRP-1:0] ce_ab_n,
   input  logic [NUM_GRP-1:0] le_ab_n,
   input  logic [NUM_GRP-1:0] oe_ab_n,
   input  logic [NUM_GRP-1:0] ce_ba_n,
   input  logic [NUM_GRP-1:0] le_ba_n,
   input  logic [NUM_GRP-1:0] oe_ba_n,
   output logic [BUS_W-1:0]   b_out,
   output logic [NUM_GRP-1:0] b_oe,
   output logic [BUS_W-1:0]   a_out,
   output logic [NUM_GRP-1:0] a_oe
);
   generate
      if (GRP_W < 1) begin : g_bad_w
         $error("xcv_bidir_latch: GRP_W must be at least 1");
      end
      if (NUM_GRP < 1) begin : g_bad_n
         $error("xcv_bidir_latch: NUM_GRP must be at least 1");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_grp
         xcv_ctrl_t c_ab, c_ba;
         assign c_ab = '{ce_n: ce_ab_n[g], le_n: le_ab_n[g], oe_n: oe_ab_n[g]};
         assign c_ba = '{ce_n: ce_ba_n[g], le_n: le_ba_n[g], oe_n: oe_ba_n[g]};

         xcv_group #(.GRP_W(GRP_W), .INVERT_OUT(INVERT_OUT)) i_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_ab (c_ab),
            .ctrl_ba (c_ba),
            .a_in    (a_in[g*GRP_W +: GRP_W]),
            .b_in    (b_in[g*GRP_W +: GRP_W]),
            .b_out   (b_out[g*GRP_W +: GRP_W]),
            .b_oe    (b_oe[g]),
            .a_out   (a_out[g*GRP_W +: GRP_W]),
            .a_oe    (a_oe[g])
         );
      end
   endgenerate
endmodule

// File: rtl/xcv_bidir_latch_chk.sv
module xcv_bidir_latch_chk #(
   parameter int GRP_W      = 8,
   parameter int NUM_GRP    = 2,
   parameter bit INVERT_OUT = 1'b1,
   localparam int BUS_W     = GRP_W * NUM_GRP
) (
   input logic               clk,
   input logic               rst_n,
   input logic [BUS_W-1:0]   a_in,
   input logic [BUS_W-1:0]   b_in,
   input logic [NUM_GRP-1:0] ce_ab_n,
   input logic [NUM_GRP-1:0] le_ab_n,
   input logic [NUM_GRP-1:0] oe_ab_n,
   input logic [NUM_GRP-1:0] ce_ba_n,
   input logic [NUM_GRP-1:0] le_ba_n,
   input logic [NUM_GRP-1:0] oe_ba_n,
   input logic [BUS_W-1:0]   b_out,
   input logic [NUM_GRP-1:0] b_oe,
   input logic [BUS_W-1:0]   a_out,
   input logic [NUM_GRP-1:0] a_oe
);
   function automatic logic [GRP_W-1:0] pol(input logic [GRP_W-1:0] v);
      return INVERT_OUT ? ~v : v;
   endfunction

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_chk
         // R2
         ce_ab_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ce_ab_n[g] |-> !b_oe[g]);
         // R3
         oe_ab_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[g] && oe_ab_n[g]) |-> !b_oe[g]);
         // R4
         flow_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[g] && !le_ab_n[g] && !oe_ab_n[g]) |->
               (b_oe[g] && b_out[g*GRP_W +: GRP_W] == pol(a_in[g*GRP_W +: GRP_W])));
         // R5
         capture_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!ce_ab_n[g] && !le_ab_n[g]) &&
             !ce_ab_n[g] && le_ab_n[g] && !oe_ab_n[g]) |->
               b_out[g*GRP_W +: GRP_W] == pol($past(a_in[g*GRP_W +: GRP_W])));
         // R6
         hold_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (ce_ab_n[g] || le_ab_n[g]) &&
             $past(ce_ab_n[g] || le_ab_n[g]) && b_oe[g] && $past(b_oe[g])) |->
               $stable(b_out[g*GRP_W +: GRP_W]));
         // R7
         ce_ba_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_ba_n[g] || oe_ba_n[g]) |-> !a_oe[g]);
         // R7
         flow_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ba_n[g] && !le_ba_n[g] && !oe_ba_n[g]) |->
               (a_oe[g] && a_out[g*GRP_W +: GRP_W] == pol(b_in[g*GRP_W +: GRP_W])));
         // R7
         hold_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (ce_ba_n[g] || le_ba_n[g]) &&
             $past(ce_ba_n[g] || le_ba_n[g]) && a_oe[g] && $past(a_oe[g])) |->
               $stable(a_out[g*GRP_W +: GRP_W]));
      end
   endgenerate
endmodule

bind xcv_bidir_latch xcv_bidir_latch_chk #(
   .GRP_W(GRP_W), .NUM_GRP(NUM_GRP), .INVERT_OUT(INVERT_OUT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
   .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
   .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
   .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
);

// File: tb/test_xcv_bidir_latch.sv
module test_xcv_bidir_latch;
   localparam int GW = 8;
   localparam int NG = 2;
   localparam int BW = GW * NG;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [BW-1:0] a_in, b_in, b_out, a_out;
   logic [NG-1:0] ce_ab_n, le_ab_n, oe_ab_n, ce_ba_n, le_ba_n, oe_ba_n, b_oe, a_oe;

   int checks = 0;
   int errors = 0;
   logic [GW-1:0] st_ab [NG];
   logic [GW-1:0] st_ba [NG];

   xcv_bidir_latch i_xcv_bidir_latch (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
      .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
   );

   function automatic string classify(logic ce, logic le, logic oe, string dir);
      if (dir == "BA") return "R7";
      if (ce) return "R2";
      if (oe) return "R3";
      if (!le) return "R4";
      return "R6";
   endfunction

   task automatic chk(string tag, logic [GW-1:0] act, logic [GW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // model-based check of every group and direction
   task automatic check_all();
      for (int g = 0; g < NG; g++) begin
         logic [GW-1:0] ai, bi;
         logic ab_drv, ba_drv;
         ai = a_in[g*GW +: GW];
         bi = b_in[g*GW +: GW];
         ab_drv = !ce_ab_n[g] && !oe_ab_n[g];
         ba_drv = !ce_ba_n[g] && !oe_ba_n[g];
         chk(classify(ce_ab_n[g], le_ab_n[g], oe_ab_n[g], "AB"), GW'(b_oe[g]), GW'(ab_drv));
         if (ab_drv)
            chk(classify(ce_ab_n[g], le_ab_n[g], oe_ab_n[g], "AB"), b_out[g*GW +: GW],
                ~((!ce_ab_n[g] && !le_ab_n[g]) ? ai : st_ab[g]));
         chk("R7", GW'(a_oe[g]), GW'(ba_drv));
         if (ba_drv)
            chk("R7", a_out[g*GW +: GW],
                ~((!ce_ba_n[g] && !le_ba_n[g]) ? bi : st_ba[g]));
      end
   endtask

   // called right after a falling edge, with inputs just applied
   task automatic cycle();
      #1;
      check_all();
      @(posedge clk);
      if (rst_n) begin
         for (int g = 0; g < NG; g++) begin
            if (!ce_ab_n[g] && !le_ab_n[g]) st_ab[g] = a_in[g*GW +: GW];
            if (!ce_ba_n[g] && !le_ba_n[g]) st_ba[g] = b_in[g*GW +: GW];
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int g = 0; g < NG; g++) begin st_ab[g] = '0; st_ba[g] = '0; end
      rst_n = 1'b0;
      a_in = 16'h5A5A; b_in = 16'hA5A5;
      ce_ab_n = '0; le_ab_n = '1; oe_ab_n = '0;
      ce_ba_n = '0; le_ba_n = '1; oe_ba_n = '0;
      @(negedge clk);
      #1;
      // R8: cleared storage shows all ones while closed and driving
      chk("R8", b_out[7:0], 8'hFF);
      chk("R8", a_out[15:8], 8'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      cycle();
      chk("R8", b_out[15:8], 8'hFF);

      // R4 + R5: open, capture, then close and change input
      le_ab_n = 2'b00; a_in = 16'h3C81;
      #1;
      chk("R4", b_out, 16'hC37E);
      #0 cycle();
      le_ab_n = 2'b11; a_in = 16'hFFFF;
      #1;
      chk("R5", b_out, 16'hC37E);
      #0 cycle();
      a_in = 16'h0000;
      #1;
      chk("R6", b_out, 16'hC37E);
      #0 cycle();

      // R2 / R3 directed
      ce_ab_n = 2'b01; oe_ab_n = 2'b10;
      #1;
      chk("R2", GW'(b_oe[0]), 8'h00);
      chk("R3", GW'(b_oe[1]), 8'h00);
      #0 cycle();

      // R1: group 0 flows, group 1 disabled and independent
      ce_ab_n = 2'b10; le_ab_n = 2'b10; oe_ab_n = 2'b00; a_in = 16'h1234;
      #1;
      chk("R1", GW'(b_oe), 8'h01);
      chk("R1", b_out[7:0], 8'hCB);
      #0 cycle();

      // R9: both directions store, only A-to-B drives
      ce_ab_n = 2'b00; le_ab_n = 2'b00; ce_ba_n = 2'b00; le_ba_n = 2'b00;
      oe_ab_n = 2'b11; oe_ba_n = 2'b11; a_in = 16'h0F0F; b_in = 16'hAAAA;
      cycle();
      le_ab_n = 2'b11; le_ba_n = 2'b11; oe_ab_n = 2'b00; oe_ba_n = 2'b11;
      a_in = 16'h7777; b_in = 16'h1111;
      #1;
      chk("R9", GW'(b_oe), 8'h03);
      chk("R9", GW'(a_oe), 8'h00);
      chk("R9", b_out, 16'hF0F0);
      #0 cycle();
      oe_ab_n = 2'b11; oe_ba_n = 2'b00;
      #1;
      chk("R9", a_out, 16'h5555);
      chk("R9", GW'(b_oe), 8'h00);
      #0 cycle();

      // constrained random mixing
      for (int i = 0; i < 400; i++) begin
         a_in = 16'($urandom);
         b_in = 16'($urandom);
         ce_ab_n = 2'($urandom) & 2'($urandom);
         ce_ba_n = 2'($urandom) & 2'($urandom);
         le_ab_n = 2'($urandom);
         le_ba_n = 2'($urandom);
         oe_ab_n = 2'($urandom) & 2'($urandom);
         oe_ba_n = 2'($urandom) & 2'($urandom);
         cycle();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule